// File: doc/BRIEF.md
# UART FIFO Status Flags

This block sits beside the transmit and receive FIFOs of a UART and turns their occupancy counts, the shifter idle indications and a handful of event strobes into one 32-bit status word for the bus. Some fields follow the live state of the datapath: activity, receiver idle, full, empty and the occupancy pointers. Others are sticky event flags that software clears by writing 1: transmit overflow and the seven receive-side error flags.

Every field is registered. A field shows the inputs sampled at the previous rising clock edge. The transmitter-done flag is set only when the transmit FIFO is empty and the stop bit of the last byte has left the line. A draining FIFO alone does not set it. The block also tells the transmit FIFO whether a bus push may be stored. A push to a full FIFO is refused, and the overflow flag records it.

Top module: `uart_fifo_flags`

## Requirements
- R1: Bit 31 (active) resets to 1. It reads 0 in the cycle after a cycle in which the disable request is high, the transmit FIFO count is 0, the transmit shifter is idle and the receive shifter is idle. In every other case it reads 1.
- R2: Bit 29 (receiver idle) resets to 1. After each clock edge it equals the receive shifter idle input sampled at that edge.
- R3: Bit 28 (transmitter done) resets to 1. It becomes 1 after an edge at which the stop-done pulse is high and the transmit FIFO count is 0. It holds 1 while the count stays 0 and the transmit shifter stays idle.
- R4: Bit 28 becomes 0 after any edge at which the transmit FIFO count is nonzero. It also becomes 0 after an edge at which the transmit shifter is busy and no stop-done pulse is present.
- R5: A push while the transmit count equals 16 sets sticky bit 24 (transmit overflow). While the count equals 16, the push-accept output is low, so that write is dropped. Otherwise push-accept follows the push input.
- R6: A register write with data bit 24 at 1 clears bit 24, and data bit 24 at 0 leaves it unchanged. If an overflow happens in the same cycle as the clear, the flag stays set.
- R7: The transmit fields are full at bit 23 (count == 16), empty at bit 22 (count == 0) and the occupancy at bits 21:16. The receive fields are full at bit 15, empty at bit 14 and the occupancy at bits 13:8. Each occupancy is the FIFO count zero-extended to 6 bits.
- R8: Bits 6:0 hold the seven receive-side event flags, set by the matching bit of the error input. A register write with 1 in the matching data bit clears a flag, and 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: Bits 30, 27:25 and 7 always read 0. The word reads 32'hB0404000 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_count | input | 5 | Transmit FIFO occupancy (0..16) |
| rx_count | input | 5 | Receive FIFO occupancy (0..16) |
| tx_push | input | 1 | Bus write to the transmit data port |
| tx_push_accept | output | 1 | Push may be stored in the transmit FIFO |
| tx_shift_idle | input | 1 | Transmit shifter is idle |
| rx_shift_idle | input | 1 | Receive shifter is idle |
| tx_stop_done | input | 1 | Pulse: stop bit of a byte has finished on the line |
| txrx_disable | input | 1 | Request to stop transmit and receive |
| rx_err_set | input | 7 | Receive-side event strobes for bits 6:0 |
| csr_wr | input | 1 | Write strobe to the status word |
| csr_wdata | input | 32 | Write data; 1 clears the matching sticky bit |
| status_word | output | 32 | Registered status word |

## Verification
The hardest situation to reach is a clear write to a sticky bit landing in the same cycle as a new set event. A close second is the transmitter-done flag rising only when a stop-done pulse arrives with an empty FIFO. Both are first driven as directed cycles. After that, random traffic is biased towards the full and empty counts and fires write strobes and stop-done pulses often, so these coincidences recur many times. A bench model updated from the requirements predicts each field one edge ahead.

// File: rtl/uart_flags_pkg.sv
// Package: field positions and shared types for the UART FIFO status word.
// Assumes the status word is 32 bits wide and the pointer fields are 6 bits wide.
package uart_flags_pkg;
    localparam int STAT_W      = 32;
    localparam int PTR_W       = 6;
    localparam int ERR_W       = 7;
    localparam int BIT_ACTIVE  = 31;
    localparam int BIT_RXIDLE  = 29;
    localparam int BIT_TXDONE  = 28;
    localparam int BIT_TXOVF   = 24;
    localparam int BIT_TXFULL  = 23;
    localparam int BIT_TXEMPTY = 22;
    localparam int TXPTR_LSB   = 16;
    localparam int BIT_RXFULL  = 15;
    localparam int BIT_RXEMPTY = 14;
    localparam int RXPTR_LSB   = 8;

    // Occupancy summary of one FIFO as shown in the status word.
    typedef struct packed {
        logic             full;
        logic             empty;
        logic [PTR_W-1:0] ptr;
    } level_t;
endpackage

// File: rtl/uart_fifo_level.sv
// Module: registers the full, empty and pointer view of one FIFO's count.
// Assumes count never exceeds DEPTH and CNT_W <= PTR_W.
module uart_fifo_level
    import uart_flags_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    output level_t           level
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Capture the occupancy summary each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level.full  <= 1'b0;
            level.empty <= 1'b1;
            level.ptr   <= '0;
        end else begin
            level.full  <= (count == FULL_CNT);
            level.empty <= (count == '0);
            level.ptr   <= PTR_W'(count);
        end
    end
endmodule

// File: rtl/uart_sticky_bank.sv
// Module: a row of sticky flags, each set by an event and cleared by write-one.
// Assumes set has priority over clear in the same cycle.
module uart_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold one flag: set wins, then clear, else keep.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_drain_tracker.sv
// Module: transmitter-done flag; set when the final stop bit is out with an empty FIFO.
// Assumes stop_done is a single-cycle pulse and the shifter reads idle after it.
module uart_tx_drain_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic shift_idle,
    input  logic stop_done,
    output logic done_flag
);
    logic keep_done;
    logic next_done;

    // Decide whether the line has fully drained after this edge.
    always_comb begin
        keep_done = done_flag && shift_idle;
        next_done = fifo_empty && (stop_done || keep_done);
    end

    // Register the drained state.
    always_ff @(posedge clk) begin
        if (!rst_n) done_flag <= 1'b1;
        else        done_flag <= next_done;
    end
endmodule

// File: rtl/uart_fifo_flags.sv
// Module: builds the 32-bit UART FIFO status word from FIFO counts, shifter
// states and event strobes; sticky bits are cleared by writing one.
// Assumes counts are in 0..DEPTH and every field is a registered view.
module uart_fifo_flags
    import uart_flags_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_push,
    output logic              tx_push_accept,
    input  logic              tx_shift_idle,
    input  logic              rx_shift_idle,
    input  logic              tx_stop_done,
    input  logic              txrx_disable,
    input  logic [ERR_W-1:0]  rx_err_set,
    input  logic              csr_wr,
    input  logic [STAT_W-1:0] csr_wdata,
    output logic [STAT_W-1:0] status_word
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam int STICKY_W = ERR_W + 1;

    level_t              tx_level;
    level_t              rx_level;
    logic                tx_full_now;
    logic                tx_idle_now;
    logic                active_q;
    logic                rxidle_q;
    logic                txdone_q;
    logic [STICKY_W-1:0] sticky_set;
    logic [STICKY_W-1:0] sticky_clr;
    logic [STICKY_W-1:0] sticky_q;
    logic                unused_wdata;

    assign unused_wdata = ^{csr_wdata[31:25], csr_wdata[23:7]};

    // Decode the live transmit conditions and the push gate.
    always_comb begin
        tx_full_now    = (tx_count == FULL_CNT);
        tx_idle_now    = tx_shift_idle && (tx_count == '0);
        tx_push_accept = tx_push && !tx_full_now;
    end

    uart_fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_level (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .level(tx_level)
    );

    uart_fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_level (
        .clk(clk), .rst_n(rst_n), .count(rx_count), .level(rx_level)
    );

    uart_tx_drain_tracker u_drain (
        .clk(clk), .rst_n(rst_n), .fifo_empty(tx_count == '0),
        .shift_idle(tx_shift_idle), .stop_done(tx_stop_done), .done_flag(txdone_q)
    );

    // Route event strobes and write-one clears to the sticky row.
    always_comb begin
        sticky_set = {tx_push && tx_full_now, rx_err_set};
        sticky_clr = csr_wr ? {csr_wdata[BIT_TXOVF], csr_wdata[ERR_W-1:0]} : '0;
    end

    uart_sticky_bank #(.W(STICKY_W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set(sticky_set), .clr(sticky_clr), .flags(sticky_q)
    );

    // Register activity and receiver idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            rxidle_q <= 1'b1;
        end else begin
            active_q <= !(txrx_disable && tx_idle_now && rx_shift_idle);
            rxidle_q <= rx_shift_idle;
        end
    end

    // Pack all fields; reserved positions stay zero.
    always_comb begin
        status_word                          = '0;
        status_word[BIT_ACTIVE]              = active_q;
        status_word[BIT_RXIDLE]              = rxidle_q;
        status_word[BIT_TXDONE]              = txdone_q;
        status_word[BIT_TXOVF]               = sticky_q[ERR_W];
        status_word[BIT_TXFULL]              = tx_level.full;
        status_word[BIT_TXEMPTY]             = tx_level.empty;
        status_word[TXPTR_LSB +: PTR_W]      = tx_level.ptr;
        status_word[BIT_RXFULL]              = rx_level.full;
        status_word[BIT_RXEMPTY]             = rx_level.empty;
        status_word[RXPTR_LSB +: PTR_W]      = rx_level.ptr;
        status_word[ERR_W-1:0]               = sticky_q[ERR_W-1:0];
    end
endmodule

// File: rtl/uart_fifo_flags_chk.sv
// Checker: temporal properties of the status word, bound to uart_fifo_flags.
// Assumes the same DEPTH and CNT_W as the bound instance.
module uart_fifo_flags_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_push,
    input logic             tx_push_accept,
    input logic             tx_shift_idle,
    input logic             rx_shift_idle,
    input logic             tx_stop_done,
    input logic             txrx_disable,
    input logic [6:0]       rx_err_set,
    input logic             csr_wr,
    input logic [31:0]      csr_wdata,
    input logic [31:0]      status_word
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (txrx_disable && tx_shift_idle && tx_count == '0 && rx_shift_idle) |=> !status_word[31]);
    assert_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !txrx_disable |=> status_word[31]);
    assert_rx_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_shift_idle |=> status_word[29]);
    assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stop_done && tx_count == '0) |=> status_word[28]);
    assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0) |=> !status_word[28]);
    assert_overflow_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_count == FULL_CNT) |=> status_word[24]);
    assert_push_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == FULL_CNT) |-> !tx_push_accept);
    assert_overflow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[24] && !(csr_wr && csr_wdata[24])) |=> status_word[24]);
    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_set != 7'd0) |=> ((status_word[6:0] & $past(rx_err_set)) == $past(rx_err_set)));
endmodule

bind uart_fifo_flags uart_fifo_flags_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .tx_push(tx_push),
    .tx_push_accept(tx_push_accept), .tx_shift_idle(tx_shift_idle),
    .rx_shift_idle(rx_shift_idle), .tx_stop_done(tx_stop_done),
    .txrx_disable(txrx_disable), .rx_err_set(rx_err_set), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .status_word(status_word)
);

// File: tb/uart_fifo_flags_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against a model.
module uart_fifo_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] tx_count = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             tx_push = 1'b0;
    logic             tx_push_accept;
    logic             tx_shift_idle = 1'b1;
    logic             rx_shift_idle = 1'b1;
    logic             tx_stop_done = 1'b0;
    logic             txrx_disable = 1'b0;
    logic [6:0]       rx_err_set = '0;
    logic             csr_wr = 1'b0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      status_word;

    int checks = 0;
    int failures = 0;

    logic             m_active = 1'b1;
    logic             m_rxidle = 1'b1;
    logic             m_txdone = 1'b1;
    logic             m_ovf = 1'b0;
    logic [6:0]       m_err = '0;
    logic [CNT_W-1:0] m_txc = '0;
    logic [CNT_W-1:0] m_rxc = '0;

    uart_fifo_flags #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .tx_push(tx_push), .tx_push_accept(tx_push_accept),
        .tx_shift_idle(tx_shift_idle), .rx_shift_idle(rx_shift_idle),
        .tx_stop_done(tx_stop_done), .txrx_disable(txrx_disable),
        .rx_err_set(rx_err_set), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .status_word(status_word)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] level_bits(input logic [CNT_W-1:0] c);
        return {c == CNT_W'(DEPTH), c == '0, 6'(c)};
    endfunction

    // Advance the model by the edge that follows the current inputs.
    task automatic model_step();
        logic clr_ovf;
        clr_ovf  = csr_wr && csr_wdata[24];
        m_active = !(txrx_disable && tx_shift_idle && tx_count == '0 && rx_shift_idle);
        m_rxidle = rx_shift_idle;
        m_txdone = (tx_count == '0) && (tx_stop_done || (m_txdone && tx_shift_idle));
        if (tx_push && tx_count == CNT_W'(DEPTH)) m_ovf = 1'b1;
        else if (clr_ovf)                         m_ovf = 1'b0;
        m_err = rx_err_set | (m_err & ~(csr_wr ? csr_wdata[6:0] : 7'd0));
        m_txc = tx_count;
        m_rxc = rx_count;
    endtask

    task automatic check_word();
        chk("R1 active",   32'(status_word[31]), 32'(m_active));
        chk("R2 rx idle",  32'(status_word[29]), 32'(m_rxidle));
        chk("R3/R4 done",  32'(status_word[28]), 32'(m_txdone));
        chk("R5/R6 ovf",   32'(status_word[24]), 32'(m_ovf));
        chk("R7 tx level", 32'(status_word[23:16]), 32'(level_bits(m_txc)));
        chk("R7 rx level", 32'(status_word[15:8]),  32'(level_bits(m_rxc)));
        chk("R8 errors",   32'(status_word[6:0]),   32'(m_err));
        chk("R9 reserved", 32'({status_word[30], status_word[27:25], status_word[7]}), 32'd0);
    endtask

    // One cycle: check push gate, let an edge pass, compare word at negedge.
    task automatic cycle();
        #1;
        chk("R5 accept", 32'(tx_push_accept), 32'(tx_push && tx_count != CNT_W'(DEPTH)));
        model_step();
        @(negedge clk);
        check_word();
    endtask

    task automatic idle_inputs();
        tx_push = 0; tx_stop_done = 0; csr_wr = 0; csr_wdata = '0;
        rx_err_set = '0; txrx_disable = 0; tx_shift_idle = 1; rx_shift_idle = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R9 reset value", status_word, 32'hB040_4000);
        rst_n = 1'b1;
        idle_inputs();
        cycle();

        // R5: push into a full FIFO; R6: write 0 does not clear.
        tx_count = 5'd16; tx_push = 1; cycle();
        tx_push = 0; csr_wr = 1; csr_wdata = 32'h0000_0000; cycle();
        // R6: set and clear in the same cycle, set wins; then clear alone.
        tx_push = 1; csr_wdata = 32'h0100_0000; cycle();
        tx_push = 0; cycle();
        csr_wr = 0; tx_count = 5'd0; cycle();

        // R4: nonzero count, then busy shifter; R3: stop bit done.
        tx_count = 5'd1; cycle();
        tx_count = 5'd0; tx_shift_idle = 0; cycle();
        tx_shift_idle = 1; cycle();
        tx_stop_done = 1; cycle();
        tx_stop_done = 0; cycle();

        // R1: disable with everything idle, then with receiver busy.
        txrx_disable = 1; cycle();
        rx_shift_idle = 0; cycle();
        rx_shift_idle = 1; txrx_disable = 0; cycle();

        // R8: set, clear-with-set collision, clear.
        rx_err_set = 7'h55; cycle();
        rx_err_set = 7'h01; csr_wr = 1; csr_wdata = 32'h0000_007F; cycle();
        rx_err_set = 7'h00; cycle();
        csr_wr = 0;

        // R7: receive full and a mid count.
        rx_count = 5'd16; cycle();
        rx_count = 5'd9; tx_count = 5'd7; cycle();

        for (int n = 0; n < 3000; n++) begin
            tx_count      = ($urandom % 4 == 0) ? 5'd16 :
                            ($urandom % 3 == 0) ? 5'd0 : 5'($urandom % 17);
            rx_count      = ($urandom % 4 == 0) ? 5'd16 : 5'($urandom % 17);
            tx_push       = ($urandom % 10) < 3;
            tx_shift_idle = ($urandom % 4) != 0;
            rx_shift_idle = ($urandom % 4) != 0;
            tx_stop_done  = ($urandom % 5) == 0;
            txrx_disable  = ($urandom % 3) == 0;
            rx_err_set    = ($urandom % 8 == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
            csr_wr        = ($urandom % 5) == 0;
            csr_wdata     = $urandom;
            cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule